// File: doc/BRIEF.md
# DMA Channel Claim and Run Register File

This block is the software-facing control and status front of a simple memory-to-memory DMA controller. It has one window of registers for each channel. Each window holds a control word, a staged descriptor (transfer config, byte count, destination address, source address) and a read-only copy of the descriptor currently in use. Software reaches these registers through a single request port that carries 4-byte and 8-byte accesses.

The control word carries the claim and run handshake. A channel has to be claimed before it can be run. Claiming an idle channel loads default descriptor values. While a transfer is running, software cannot release the claim. When a run is accepted, the staged descriptor is copied into the in-use copy and the block sends a one-cycle start pulse to the transfer engine. The engine answers with done and error pulses, which set status bits. Each channel drives a done interrupt line and an error interrupt line, and each line is gated by its own enable bit.

Top module: `dma_claim_regs`

## Requirements
- R1: After reset, every channel's control word reads 0, its staged config reads 0x6600_0000 and all interrupt lines are low.
- R2: A control write that sets claim (bit 0) on an unclaimed channel sets the staged config to 0x6600_0000 (read size in bits 31:28 and write size in bits 27:24 both 6). It also clears the staged byte count, destination and source to zero.
- R3: A control write that sets run (bit 1) on a channel that was unclaimed before the write stores run as 0 and emits no start pulse. The same holds when the write drops claim while run was low.
- R4: Setting run on a claimed channel does three things: it emits exactly one start pulse on start[n] in the cycle after the write, it copies the staged descriptor into the read-only copy (config 0x104, bytes 0x108, destination 0x110, source 0x118), and it clears both status bits.
- R5: A control write that clears claim while run is set leaves claim reading 1.
- R6: A done pulse from the engine sets done status (bit 30) and clears run. An error pulse sets error status (bit 31).
- R7: irq[2n] equals done-enable (bit 14) AND done status. irq[2n+1] equals error-enable (bit 15) AND error status.
- R8: The staged byte count (0x008), destination (0x010) and source (0x018) can be written and read whole with an 8-byte access, or as 32-bit halves with the low half at the base offset and the high half at base+4.
- R9: Writes of any size to the read-only copy at offsets 0x104 to 0x11C are ignored.
- R10: An access whose size code is neither 2 (4 bytes) nor 3 (8 bytes), or whose offset is unmapped for its size (an 8-byte access to 0x000, for example), reads as zero and writes nothing.
- R11: The channel index is taken from address bits above bit 11. An index of NUM_CH or more reads zero and its writes change nothing.
- R12: Every read request returns its data on rd_data with rd_valid high exactly one cycle later. A 4-byte read returns its value in bits 31:0 with bits 63:32 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address: channel index in bits above 11, offset in 11:0 |
| req_size | input | 2 | Log2 of access size in bytes (2 or 3 are legal) |
| req_wdata | input | 64 | Write data (4-byte writes use bits 31:0) |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 64 | Read data |
| eng_done | input | NUM_CH | Per-channel transfer complete pulse from the engine |
| eng_err | input | NUM_CH | Per-channel transfer error pulse from the engine |
| start | output | NUM_CH | Per-channel one-cycle start pulse to the engine |
| irq | output | 2*NUM_CH | Done (even) and error (odd) interrupt lines |

## Verification
The assertions assume two things about the inputs. First, the engine raises eng_done or eng_err for a channel only after that channel has received a start pulse. Second, an engine pulse never lands in the same cycle as a control write to the same channel, because the write would take priority over it. The stimulus respects both: engine pulses are sent only after a run has been accepted and the bus is idle, and each request is a single isolated cycle. Within those limits the bench exercises the claim, run and release corner cases, split and whole 64-bit access, read-only and unmapped accesses, and an out-of-range channel index.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    localparam int REG_W = 64;
    localparam int CFG_W = 32;

    localparam logic [1:0] SZ_WORD  = 2'd2;
    localparam logic [1:0] SZ_DWORD = 2'd3;

    localparam logic [11:0] OFF_CTRL     = 12'h000;
    localparam logic [11:0] OFF_NCFG     = 12'h004;
    localparam logic [11:0] OFF_NBYTES   = 12'h008;
    localparam logic [11:0] OFF_NDST     = 12'h010;
    localparam logic [11:0] OFF_NSRC     = 12'h018;
    localparam logic [11:0] OFF_XCFG     = 12'h104;
    localparam logic [11:0] OFF_XBYTES   = 12'h108;
    localparam logic [11:0] OFF_XDST     = 12'h110;
    localparam logic [11:0] OFF_XSRC     = 12'h118;

    localparam int B_CLAIM  = 0;
    localparam int B_RUN    = 1;
    localparam int B_DIE    = 14;
    localparam int B_EIE    = 15;
    localparam int B_DONE   = 30;
    localparam int B_ERR    = 31;

    localparam logic [CFG_W-1:0] CFG_DEFAULT = 32'h6600_0000;

    typedef struct packed {
        logic             claim;
        logic             run;
        logic             done_ie;
        logic             err_ie;
        logic             done;
        logic             err;
        logic             start;
        logic [CFG_W-1:0] next_cfg;
        logic [REG_W-1:0] next_bytes;
        logic [REG_W-1:0] next_dst;
        logic [REG_W-1:0] next_src;
        logic [CFG_W-1:0] exec_cfg;
        logic [REG_W-1:0] exec_bytes;
        logic [REG_W-1:0] exec_dst;
        logic [REG_W-1:0] exec_src;
    } chan_state_t;

    function automatic logic [REG_W-1:0] put_half(input logic [REG_W-1:0] old,
                                                 input logic hi,
                                                 input logic [31:0] v);
        logic [REG_W-1:0] r;
        r = old;
        if (hi) r[63:32] = v;
        else    r[31:0]  = v;
        return r;
    endfunction

endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 16,
    localparam int IDX_W = ADDR_W - 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [11:0]       off_o,
    output logic              wide_o,
    output logic              hit_o
);
    logic size_ok;

    always_comb begin
        idx_o   = addr_i[ADDR_W-1:12];
        off_o   = addr_i[11:0];
        wide_o  = (size_i == SZ_DWORD);
        size_ok = (size_i == SZ_WORD) || (size_i == SZ_DWORD);
        hit_o   = size_ok && (32'(idx_o) < NUM_CH);
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wide_i,
    input  logic [11:0]      off_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             eng_done_i,
    input  logic             eng_err_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             start_o,
    output logic             irq_done_o,
    output logic             irq_err_o
);
    chan_state_t s_d, s_q;
    logic        ctl_wr;
    logic        exec_wr;
    logic [31:0] w32;

    assign w32     = wdata_i[31:0];
    assign ctl_wr  = wr_en_i && !wide_i && (off_i == OFF_CTRL);
    assign exec_wr = wr_en_i && (off_i >= OFF_XCFG) && (off_i <= 12'h11C);

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (eng_done_i) begin
            s_d.done = 1'b1;
            s_d.run  = 1'b0;
        end
        if (eng_err_i) s_d.err = 1'b1;

        if (wr_en_i && wide_i) begin
            case (off_i)
                OFF_NBYTES: s_d.next_bytes = wdata_i;
                OFF_NDST:   s_d.next_dst   = wdata_i;
                OFF_NSRC:   s_d.next_src   = wdata_i;
                default: ;
            endcase
        end else if (wr_en_i) begin
            case (off_i)
                OFF_CTRL: begin
                    if (!s_q.claim && w32[B_CLAIM]) begin
                        s_d.next_cfg   = CFG_DEFAULT;
                        s_d.next_bytes = '0;
                        s_d.next_dst   = '0;
                        s_d.next_src   = '0;
                    end
                    s_d.claim   = w32[B_CLAIM] | s_q.run;
                    s_d.run     = w32[B_RUN];
                    s_d.done_ie = w32[B_DIE];
                    s_d.err_ie  = w32[B_EIE];
                    s_d.done    = w32[B_DONE];
                    s_d.err     = w32[B_ERR];
                    if (!s_q.claim || (!s_q.run && !w32[B_CLAIM])) begin
                        s_d.run = 1'b0;
                    end else if (w32[B_RUN]) begin
                        s_d.start      = 1'b1;
                        s_d.done       = 1'b0;
                        s_d.err        = 1'b0;
                        s_d.exec_cfg   = s_q.next_cfg;
                        s_d.exec_bytes = s_q.next_bytes;
                        s_d.exec_dst   = s_q.next_dst;
                        s_d.exec_src   = s_q.next_src;
                    end
                end
                OFF_NCFG:         s_d.next_cfg   = w32;
                OFF_NBYTES:       s_d.next_bytes = put_half(s_q.next_bytes, 1'b0, w32);
                OFF_NBYTES + 12'd4: s_d.next_bytes = put_half(s_q.next_bytes, 1'b1, w32);
                OFF_NDST:         s_d.next_dst   = put_half(s_q.next_dst, 1'b0, w32);
                OFF_NDST + 12'd4: s_d.next_dst   = put_half(s_q.next_dst, 1'b1, w32);
                OFF_NSRC:         s_d.next_src   = put_half(s_q.next_src, 1'b0, w32);
                OFF_NSRC + 12'd4: s_d.next_src   = put_half(s_q.next_src, 1'b1, w32);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.next_cfg <= CFG_DEFAULT;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (wide_i) begin
            case (off_i)
                OFF_NBYTES: rdata_o = s_q.next_bytes;
                OFF_NDST:   rdata_o = s_q.next_dst;
                OFF_NSRC:   rdata_o = s_q.next_src;
                OFF_XBYTES: rdata_o = s_q.exec_bytes;
                OFF_XDST:   rdata_o = s_q.exec_dst;
                OFF_XSRC:   rdata_o = s_q.exec_src;
                default: ;
            endcase
        end else begin
            case (off_i)
                OFF_CTRL: begin
                    rdata_o[B_CLAIM] = s_q.claim;
                    rdata_o[B_RUN]   = s_q.run;
                    rdata_o[B_DIE]   = s_q.done_ie;
                    rdata_o[B_EIE]   = s_q.err_ie;
                    rdata_o[B_DONE]  = s_q.done;
                    rdata_o[B_ERR]   = s_q.err;
                end
                OFF_NCFG:           rdata_o[31:0] = s_q.next_cfg;
                OFF_NBYTES:         rdata_o[31:0] = s_q.next_bytes[31:0];
                OFF_NBYTES + 12'd4: rdata_o[31:0] = s_q.next_bytes[63:32];
                OFF_NDST:           rdata_o[31:0] = s_q.next_dst[31:0];
                OFF_NDST + 12'd4:   rdata_o[31:0] = s_q.next_dst[63:32];
                OFF_NSRC:           rdata_o[31:0] = s_q.next_src[31:0];
                OFF_NSRC + 12'd4:   rdata_o[31:0] = s_q.next_src[63:32];
                OFF_XCFG:           rdata_o[31:0] = s_q.exec_cfg;
                OFF_XBYTES:         rdata_o[31:0] = s_q.exec_bytes[31:0];
                OFF_XBYTES + 12'd4: rdata_o[31:0] = s_q.exec_bytes[63:32];
                OFF_XDST:           rdata_o[31:0] = s_q.exec_dst[31:0];
                OFF_XDST + 12'd4:   rdata_o[31:0] = s_q.exec_dst[63:32];
                OFF_XSRC:           rdata_o[31:0] = s_q.exec_src[31:0];
                OFF_XSRC + 12'd4:   rdata_o[31:0] = s_q.exec_src[63:32];
                default: ;
            endcase
        end
    end

    assign start_o    = s_q.start;
    assign irq_done_o = s_q.done_ie & s_q.done;
    assign irq_err_o  = s_q.err_ie & s_q.err;

    // R5
    claim_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && s_q.run && !w32[B_CLAIM]) |=> s_q.claim);

    // R2
    claim_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.claim) |-> (s_q.next_cfg == CFG_DEFAULT && s_q.next_bytes == '0
                              && s_q.next_dst == '0 && s_q.next_src == '0));

    // R3
    start_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.start |-> $past(s_q.claim));

    // R9
    exec_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_wr |=> ($stable(s_q.exec_cfg) && $stable(s_q.exec_bytes)
                     && $stable(s_q.exec_dst) && $stable(s_q.exec_src)));

    // R6
    done_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done_i && !ctl_wr) |=> (s_q.done && !s_q.run));
endmodule

// File: rtl/dma_claim_regs.sv
module dma_claim_regs
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [REG_W-1:0]  req_wdata,
    output logic              rd_valid,
    output logic [REG_W-1:0]  rd_data,
    input  logic [NUM_CH-1:0] eng_done,
    input  logic [NUM_CH-1:0] eng_err,
    output logic [NUM_CH-1:0] start,
    output logic [2*NUM_CH-1:0] irq
);
    localparam int IDX_W = ADDR_W - 12;

    typedef struct packed {
        logic             vld;
        logic [REG_W-1:0] data;
    } rsp_t;

    rsp_t             r_d, r_q;
    logic [IDX_W-1:0] idx;
    logic [11:0]      off;
    logic             wide;
    logic             hit;
    logic [REG_W-1:0] ch_rdata [NUM_CH];

    dma_reg_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr_i (req_addr),
        .size_i (req_size),
        .idx_o  (idx),
        .off_o  (off),
        .wide_o (wide),
        .hit_o  (hit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = hit && (idx == IDX_W'(c));
        dma_chan_regs u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en_i    (req_valid && req_write && sel),
            .wide_i     (wide),
            .off_i      (off),
            .wdata_i    (req_wdata),
            .eng_done_i (eng_done[c]),
            .eng_err_i  (eng_err[c]),
            .rdata_o    (ch_rdata[c]),
            .start_o    (start[c]),
            .irq_done_o (irq[2*c]),
            .irq_err_o  (irq[2*c+1])
        );
    end

    always_comb begin
        r_d.vld  = req_valid && !req_write;
        r_d.data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit && idx == IDX_W'(c)) r_d.data = ch_rdata[c];
        end
        if (!r_d.vld) r_d.data = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_valid = r_q.vld;
    assign rd_data  = r_q.data;

    // R12
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R11
    oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !hit) |=> (rd_data == '0));
endmodule

// File: tb/dma_claim_regs_tb.sv
module dma_claim_regs_tb;
    localparam int NUM_CH = 2;
    localparam int ADDR_W = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_write = 1'b0;
    logic [ADDR_W-1:0]   req_addr = '0;
    logic [1:0]          req_size = 2'd2;
    logic [63:0]         req_wdata = '0;
    logic                rd_valid;
    logic [63:0]         rd_data;
    logic [NUM_CH-1:0]   eng_done = '0;
    logic [NUM_CH-1:0]   eng_err = '0;
    logic [NUM_CH-1:0]   start;
    logic [2*NUM_CH-1:0] irq;

    int total = 0;
    int bad = 0;
    int start_cnt [NUM_CH];
    logic [63:0] exp_q [$];
    string       tag_q [$];
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_claim_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .eng_done(eng_done),
        .eng_err(eng_err), .start(start), .irq(irq)
    );

    initial for (int c = 0; c < NUM_CH; c++) start_cnt[c] = 0;

    always @(negedge clk) begin
        for (int c = 0; c < NUM_CH; c++) if (rst_n && start[c]) start_cnt[c]++;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R12 unexpected read data: actual=%h expected=none", rd_data);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", t, rd_data, e);
                end
            end
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string t);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                      input logic [63:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_done(input int c);
        @(negedge clk); eng_done[c] = 1'b1;
        @(negedge clk); eng_done[c] = 1'b0;
    endtask

    task automatic pulse_err(input int c);
        @(negedge clk); eng_err[c] = 1'b1;
        @(negedge clk); eng_err[c] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(16'h0000, 2'd2, 64'h0, "R1 ctrl after reset");
        rd(16'h0004, 2'd2, 64'h6600_0000, "R1 config after reset");
        chk(64'(irq), 64'h0, "R1 irq after reset");

        // R2 claim resets staged descriptor
        wr(16'h0008, 2'd2, 64'h1234);
        rd(16'h0008, 2'd2, 64'h1234, "R8 bytes low half");
        wr(16'h0004, 2'd2, 64'h0000_000C);
        wr(16'h0000, 2'd2, 64'h1);
        rd(16'h0008, 2'd3, 64'h0, "R2 bytes cleared on claim");
        rd(16'h0004, 2'd2, 64'h6600_0000, "R2 config default on claim");
        rd(16'h0000, 2'd2, 64'h1, "R2 claim stored");

        // R3 run without claim, and claim dropped with run low
        wr(16'h1000, 2'd2, 64'h2);
        rd(16'h1000, 2'd2, 64'h0, "R3 run needs claim");
        wr(16'h1000, 2'd2, 64'h1);
        wr(16'h1000, 2'd2, 64'h2);
        rd(16'h1000, 2'd2, 64'h0, "R3 drop claim run low");
        idle(2);
        chk(64'(start_cnt[1]), 64'd0, "R3 no start on ch1");

        // R8 wide and split access
        wr(16'h0010, 2'd3, 64'hAAAA_BBBB_CCCC_DDDD);
        rd(16'h0010, 2'd2, 64'hCCCC_DDDD, "R12 low half upper zero");
        rd(16'h0014, 2'd2, 64'hAAAA_BBBB, "R8 dst high half");
        wr(16'h001C, 2'd2, 64'h11);
        wr(16'h0018, 2'd2, 64'h22);
        rd(16'h0018, 2'd3, 64'h0000_0011_0000_0022, "R8 src halves to whole");
        wr(16'h0008, 2'd3, 64'h100);

        // R4 run on claimed channel
        wr(16'h0000, 2'd2, 64'h0000_C003);
        idle(2);
        chk(64'(start_cnt[0]), 64'd1, "R4 one start pulse");
        rd(16'h0108, 2'd3, 64'h100, "R4 exec bytes copy");
        rd(16'h0110, 2'd3, 64'hAAAA_BBBB_CCCC_DDDD, "R4 exec dst copy");
        rd(16'h0118, 2'd3, 64'h0000_0011_0000_0022, "R4 exec src copy");
        rd(16'h0104, 2'd2, 64'h6600_0000, "R4 exec config copy");

        // R6 / R7 done
        pulse_done(0);
        idle(1);
        rd(16'h0000, 2'd2, 64'h4000_C001, "R6 done set run cleared");
        chk(64'(irq[0]), 64'd1, "R7 done irq raised");
        chk(64'(irq[1]), 64'd0, "R7 err irq low");

        // R4 restart clears status
        wr(16'h0000, 2'd2, 64'h0000_C003);
        idle(2);
        chk(64'(start_cnt[0]), 64'd2, "R4 second start pulse");
        chk(64'(irq[0]), 64'd0, "R4 status cleared on start");

        // R5 claim release blocked while running
        wr(16'h0000, 2'd2, 64'h0);
        rd(16'h0000, 2'd2, 64'h1, "R5 claim held while running");

        // R6 / R7 error, with enable gating
        pulse_err(0);
        idle(1);
        rd(16'h0000, 2'd2, 64'h8000_0001, "R6 error status set");
        chk(64'(irq[1]), 64'd0, "R7 err irq gated by enable");
        wr(16'h0000, 2'd2, 64'h8000_8001);
        idle(1);
        chk(64'(irq[1]), 64'd1, "R7 err irq with enable");
        chk(64'(start_cnt[0]), 64'd2, "R4 no start without run");

        // R9 exec copy is read-only
        wr(16'h0108, 2'd3, 64'hFFFF);
        wr(16'h0104, 2'd2, 64'h1);
        wr(16'h0110, 2'd2, 64'h5);
        rd(16'h0108, 2'd3, 64'h100, "R9 exec bytes unchanged");
        rd(16'h0104, 2'd2, 64'h6600_0000, "R9 exec config unchanged");
        rd(16'h0110, 2'd2, 64'hCCCC_DDDD, "R9 exec dst unchanged");

        // R10 bad size and unmapped offset
        wr(16'h0008, 2'd1, 64'h55);
        rd(16'h0008, 2'd3, 64'h100, "R10 bad size write ignored");
        rd(16'h0008, 2'd1, 64'h0, "R10 bad size read zero");
        wr(16'h0020, 2'd2, 64'h77);
        rd(16'h0020, 2'd2, 64'h0, "R10 unmapped reads zero");
        rd(16'h0000, 2'd3, 64'h0, "R10 wide access to ctrl");

        // R11 out-of-range channel
        wr(16'h3000, 2'd2, 64'h1);
        rd(16'h3000, 2'd2, 64'h0, "R11 out of range reads zero");
        rd(16'h1000, 2'd2, 64'h0, "R11 ch1 untouched");
        rd(16'h1004, 2'd2, 64'h6600_0000, "R11 ch1 config readable");

        idle(3);
        chk(64'(exp_q.size()), 64'd0, "R12 every read answered");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule